// File: doc/BRIEF.md
# Dual-Slope Integrating ADC Controller

This block holds the digital sequencing and counting for a dual-slope integrating analogue-to-digital converter. The integrator and its zero-crossing comparator sit outside the block. The block controls them through two outputs: a discharge strobe and an input-select line. It reads back a single comparator bit.

A pulse on `start` begins a conversion, which runs in three steps:

1. **Clear.** The discharge strobe is held for one cycle to empty the integrator.
2. **Run-up.** The integrator is fed from the unknown input for a fixed window of 2^CNT_W clocks. The window ends when the block's own CNT_W-bit counter wraps from all ones to zero.
3. **Run-down.** The select line moves to the opposite-polarity reference and the same counter keeps counting from zero. The run-down stops when the comparator reports that the integrator has returned to zero.

At that point the count is captured as the result and `done` pulses for one cycle. The result is the ratio of the input to the reference scaled to the counter range, and it does not depend on the integrator's RC or on the clock rate. A conversion takes roughly 2 × 2^CNT_W clocks.

If the comparator has not fired by the time the run-down counter reaches all ones, the result saturates at all ones and an overrange flag is raised.

The controller has five states:

| State | What happens | Leaves on |
|---|---|---|
| IDLE | Waits for work | `start` goes to CLEAR |
| CLEAR | Drives the discharge strobe | The next cycle, to RUNUP |
| RUNUP | Integrates the unknown input | Counter at all ones, to RUNDOWN |
| RUNDOWN | Integrates the reference | Comparator high or counter at all ones, to DONE |
| DONE | Pulses `done` | The next cycle, to IDLE |

Top module: `dual_slope_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `int_clear`, `sel_ref`, `done`, `overrange` are 0 and `result` is 0.
- R2: `start` sampled high in IDLE makes `int_clear` high for exactly one cycle, and the run-up follows. `start` sampled in any other state has no effect on the conversion timing or its result.
- R3: The run-up keeps `sel_ref` at 0 (unknown input) for exactly 2^CNT_W cycles. During it the counter runs from 0 up to all ones, and the run-up ends on the wrap to 0.
- R4: On that wrap `sel_ref` becomes 1 (reference) and the counter continues from 0. In the run-down cycle whose count is K, a high `zero_cross` sampled at the closing edge stops the counter and stores K in `result`.
- R5: `done` is high for exactly one cycle, the cycle right after the capturing edge. In that cycle `sel_ref` is already 0, and the block is back in IDLE one cycle later.
- R6: If `zero_cross` is still low at the edge closing the run-down cycle with count all ones, `result` becomes all ones and `overrange` becomes 1. A high `zero_cross` in that same cycle is an ordinary capture: `result` becomes all ones and `overrange` becomes 0.
- R7: `result` and `overrange` change only at a capture, so they hold their values while IDLE and through the next conversion until its capture.
- R8: The result depends only on the ratio of input to reference. Scaling both by the same factor gives the same code.
- R9: Pulling `rst_n` low mid-conversion abandons the conversion and returns every output to its R1 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a conversion when sampled high in IDLE |
| zero_cross | input | 1 | Comparator: 1 when the integrator output has returned to zero (synchronous to `clk`) |
| int_clear | output | 1 | Integrator discharge strobe, high during the clear step |
| sel_ref | output | 1 | Integrator input select: 0 selects the unknown input, 1 selects the reference |
| result | output | CNT_W | Last captured conversion code |
| overrange | output | 1 | Set when the last conversion saturated without a comparator trip |
| done | output | 1 | One-cycle pulse after a capture |

## Verification
The capture by the comparator and the overrange saturation both fire in the run-down cycle whose count is all ones. Only the comparator level at that edge decides between them.

The bench provokes the collision with full-scale inputs from an integrating model. One input makes the model cross zero in exactly that terminal cycle; another input, one step larger, makes it miss the crossing. The first must give all ones with the flag clear, and the second all ones with the flag set.

Start pulses injected during run-up and run-down are judged by the run-up length and the result staying unchanged.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_CLEAR    = 3'd1,
        ST_RUNUP    = 3'd2,
        ST_RUNDOWN  = 3'd3,
        ST_DONE     = 3'd4
    } dsadc_state_e;

endpackage

// File: rtl/dsadc_counter.sv
module dsadc_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         at_max
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (en) begin
            count <= count + 1'b1;   // wraps from TOP to zero
        end
    end

    assign at_max = (count == TOP);
endmodule

// File: rtl/dsadc_capture.sv
module dsadc_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         sat,
    input  logic [W-1:0] count_in,
    output logic [W-1:0] code,
    output logic         flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code <= '0;
            flag <= 1'b0;
        end else if (load) begin
            code <= sat ? {W{1'b1}} : count_in;
            flag <= sat;
        end
    end
endmodule

// File: rtl/dual_slope_ctrl.sv
module dual_slope_ctrl
    import dsadc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             zero_cross,
    output logic             int_clear,
    output logic             sel_ref,
    output logic [CNT_W-1:0] result,
    output logic             overrange,
    output logic             done
);
    dsadc_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             cnt_top;
    logic             cnt_clr, cnt_en;
    logic             cap_load, cap_sat;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and datapath controls
    always_comb begin
        state_d  = state_q;
        cnt_clr  = 1'b0;
        cnt_en   = 1'b0;
        cap_load = 1'b0;
        cap_sat  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) state_d = ST_CLEAR;
            end
            ST_CLEAR: begin
                cnt_clr = 1'b1;
                state_d = ST_RUNUP;
            end
            ST_RUNUP: begin
                cnt_en = 1'b1;
                if (cnt_top) state_d = ST_RUNDOWN;   // wrap ends the fixed window
            end
            ST_RUNDOWN: begin
                if (zero_cross) begin
                    cap_load = 1'b1;
                    state_d  = ST_DONE;
                end else if (cnt_top) begin
                    cap_load = 1'b1;
                    cap_sat  = 1'b1;
                    state_d  = ST_DONE;
                end else begin
                    cnt_en = 1'b1;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        int_clear = (state_q == ST_CLEAR);
        sel_ref   = (state_q == ST_RUNDOWN);
        done      = (state_q == ST_DONE);
    end

    dsadc_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (cnt_clr),
        .en     (cnt_en),
        .count  (cnt_q),
        .at_max (cnt_top)
    );

    dsadc_capture #(.W(CNT_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cap_load),
        .sat      (cap_sat),
        .count_in (cnt_q),
        .code     (result),
        .flag     (overrange)
    );
endmodule

// File: rtl/dual_slope_ctrl_chk.sv
module dual_slope_ctrl_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             int_clear,
    input logic             sel_ref,
    input logic             done,
    input logic             overrange,
    input logic [CNT_W-1:0] result,
    input logic [CNT_W-1:0] cnt_q
);
    // R2: discharge lasts one cycle and only follows a start request
    a_r2_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        int_clear |=> !int_clear);
    a_r2_clear_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_clear) |-> $past(start));

    // R3: switch to reference happens on the counter wrap
    a_r3_wrap_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sel_ref) |-> (cnt_q == '0) && ($past(cnt_q) == {CNT_W{1'b1}}));

    // R5: done is a single pulse directly after the run-down
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r5_done_after_rundown: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(sel_ref) && !sel_ref);

    // R6: overrange always comes with a saturated code
    a_r6_sat_code: assert property (@(posedge clk) disable iff (!rst_n)
        overrange |-> (result == {CNT_W{1'b1}}));

    // R7: result and flag only move at a capture
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result) && $stable(overrange));
endmodule

bind dual_slope_ctrl dual_slope_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .int_clear (int_clear),
    .sel_ref   (sel_ref),
    .done      (done),
    .overrange (overrange),
    .result    (result),
    .cnt_q     (cnt_q)
);

// File: tb/dual_slope_ctrl_test.sv
`timescale 1ns/1ps
module dual_slope_ctrl_test;
    localparam int N      = 6;
    localparam int RUNUP  = 1 << N;
    localparam int FULL   = RUNUP - 1;
    localparam int NVEC   = 14;

    // {vin, vref, expected result, expected overrange}
    localparam int VEC [NVEC][4] = '{
        '{  0,  64,  0, 0},
        '{  1,  64,  0, 0},
        '{  2,  64,  1, 0},
        '{ 32,  64, 31, 0},
        '{ 64, 128, 31, 0},
        '{ 16,  32, 31, 0},
        '{ 64,  64, 63, 0},
        '{ 65,  64, 63, 1},
        '{200,  64, 63, 1},
        '{ 10, 100,  6, 0},
        '{ 37,  50, 47, 0},
        '{ 99, 128, 49, 0},
        '{127, 128, 63, 0},
        '{129, 128, 63, 1}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic         zero_cross = 1'b0;
    logic         int_clear, sel_ref, overrange, done;
    logic [N-1:0] result;

    int  checks = 0;
    int  fails  = 0;
    longint acc = 0;
    int  vin = 0;
    int  vref = 1;

    always #2 clk = ~clk;   // 250 MHz

    dual_slope_ctrl #(.CNT_W(N)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .zero_cross (zero_cross),
        .int_clear  (int_clear),
        .sel_ref    (sel_ref),
        .result     (result),
        .overrange  (overrange),
        .done       (done)
    );

    // Integrator and comparator model
    always @(negedge clk) begin
        if (int_clear)    acc = 0;
        else if (sel_ref) acc = acc - vref;
        else              acc = acc + vin;
        zero_cross = (acc <= 0);
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_conv(input int vi, input int vr, input int poke,
                            output int res, output int ovr, output int runup,
                            output int clears, output int done_next,
                            output int sel_at_done);
        int cyc;
        int seen_ref;
        @(negedge clk);
        vin = vi; vref = vr; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        clears = 0; runup = 0; seen_ref = 0; cyc = 0;
        while (!done && cyc < 1000) begin
            if (int_clear) clears++;
            if (sel_ref) seen_ref = 1;
            if (!int_clear && !sel_ref && !seen_ref && clears > 0) runup++;
            start = (poke > 0 && cyc == poke);
            @(negedge clk);
            cyc++;
        end
        start = 1'b0;
        res = int'(result);
        ovr = int'(overrange);
        sel_at_done = int'(sel_ref);
        @(negedge clk);
        done_next = int'(done);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int r, o, ru, cl, dn, sd;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 int_clear", int'(int_clear), 0);
        check("R1 sel_ref", int'(sel_ref), 0);
        check("R1 done", int'(done), 0);
        check("R1 result", int'(result), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 overrange after release", int'(overrange), 0);

        // Table of vectors: R3 R4 R5 R6 R8
        foreach (VEC[i]) begin
            run_conv(VEC[i][0], VEC[i][1], 0, r, o, ru, cl, dn, sd);
            check("R4/R8 result", r, VEC[i][2]);
            check("R6 overrange", o, VEC[i][3]);
            check("R3 run-up length", ru, RUNUP);
            check("R2 clear length", cl, 1);
            check("R5 done single", dn, 0);
            check("R5 sel_ref at done", sd, 0);
        end

        // R7: values hold while idle
        repeat (20) @(negedge clk);
        check("R7 result held", int'(result), FULL);
        check("R7 overrange held", int'(overrange), 1);

        // R2: start during run-up and run-down is ignored
        run_conv(37, 50, 10, r, o, ru, cl, dn, sd);
        check("R2 poke run-up result", r, 47);
        check("R2 poke run-up length", ru, RUNUP);
        run_conv(37, 50, 90, r, o, ru, cl, dn, sd);
        check("R2 poke run-down result", r, 47);
        check("R2 poke run-down clear", cl, 1);

        // R7: during the next conversion the old result stays until capture
        @(negedge clk);
        vin = 10; vref = 100; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (RUNUP + 2) @(negedge clk);
        check("R7 result during conversion", int'(result), 47);

        // R9: reset mid-conversion
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 sel_ref", int'(sel_ref), 0);
        check("R9 int_clear", int'(int_clear), 0);
        check("R9 result", int'(result), 0);
        check("R9 done", int'(done), 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check("R9 stays idle", int'(int_clear | sel_ref | done), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule